// File: doc/BRIEF.md
# Piecewise-Linear Thermal Code Converter

This block turns a raw reading from an on-die temperature sensor ADC into a signed temperature in millidegrees Celsius. The calibration curve is a set of breakpoints, computed from parameters when the design is elaborated. Each breakpoint pairs an ADC code with a temperature. The block finds the two breakpoints on either side of the incoming code with a binary search. It then interpolates linearly between them with a restoring sequential divider, so the result is finer than the 5 °C spacing of the breakpoints.

The breakpoint codes can either climb or fall as the temperature rises, and a mode input picks which curve a conversion uses. A reading that lies outside the curve is not converted; the block flags it as an error instead. A client hands over a code on a valid/ready handshake. Some tens of cycles later the block returns one result pulse, which carries the temperature and an error bit. The block takes one conversion at a time.

Top module: `thermo_code_conv`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: A code is taken only in a cycle where in_valid and in_ready are both 1. From the cycle after that, in_ready stays 0 until the result is delivered. Each accepted code gives exactly one result, and out_valid is high for a single cycle. in_ready returns to 1 in the cycle after out_valid.
- R3: Only the low DATA_W bits of in_code are used. The bits above them have no effect on the result.
- R4: Rising curve (in_fall=0). Entry 0 is code 0 at T0. For k = 0..NPTS-1, entry k+1 is code C_RISE + k*STEP + floor(k/BEND) at T0 + k*TSTEP. The last entry, NPTS+1, is the full-scale code 2^DATA_W-1 at the top temperature T0+(NPTS-1)*TSTEP.
- R5: Falling curve (in_fall=1). Entry 0 is the full-scale code at T0. For k = 0..NPTS-1, entry k+1 is code C_FALL - k*STEP - floor(k/BEND) at T0 + k*TSTEP. The curve has no entry after entry NPTS.
- R6: On the rising curve, a masked code below the code of entry 1 gives out_err=1 and out_temp=0.
- R7: On the falling curve, a masked code below the code of entry NPTS gives out_err=1 and out_temp=0. So does a code for which no bracketing pair exists, which means the full-scale code.
- R8: For the bracketing pair (m-1, m), the result is temp[m-1] + floor((temp[m]-temp[m-1]) * |code[m-1]-code| / |code[m-1]-code[m]|). On the rising curve the pair satisfies code[m-1] < code <= code[m]. On the falling curve it satisfies code[m-1] > code >= code[m].
- R9: The sentinel intervals clamp the result. On the rising curve, a code above the top breakpoint gives the top temperature. On the falling curve, a code between entry 1 and full scale (full scale itself excluded) gives T0.
- R10: A result without error always lies between T0 and the top temperature, both included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A code is offered |
| in_ready | output | 1 | The block is idle and will take a code |
| in_code | input | IN_W | Raw ADC code; the bits above DATA_W are ignored |
| in_fall | input | 1 | Curve select: 0 rising codes, 1 falling codes |
| out_valid | output | 1 | One-cycle result pulse |
| out_temp | output | TEMP_W | Signed temperature in millidegrees |
| out_err | output | 1 | The reading was rejected |

## Verification
The bench uses the default parameters. The 12-bit input and 10-bit data width let it test the masking with upper bits set. The 34 breakpoints from -40000 to 125000 m°C, together with an uneven step (STEP=8, with one extra count every third interval), give brackets with divisors of 8 and 9, so the quotient is truncated. It sweeps every third code in both modes, which covers both sentinel intervals, the full-scale code that cannot be bracketed, and the exact breakpoint codes.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_DIV    = 2'd2,
        ST_DONE   = 2'd3
    } conv_state_e;

    // Code of breakpoint idx; fall selects the falling curve.
    function automatic int bp_code(input logic fall, input int idx,
                                   input int data_w, input int npts,
                                   input int c_rise, input int c_fall,
                                   input int step, input int bend);
        int full;
        int k;
        full = (1 << data_w) - 1;
        k    = idx - 1;
        if (idx <= 0)
            return fall ? full : 0;
        if (idx > npts)
            return full;
        if (fall)
            return c_fall - k * step - k / bend;
        return c_rise + k * step + k / bend;
    endfunction

    // Temperature of breakpoint idx (same for both curves).
    function automatic int bp_temp(input int idx, input int npts,
                                   input int t0, input int tstep);
        if (idx <= 0)
            return t0;
        if (idx > npts)
            return t0 + (npts - 1) * tstep;
        return t0 + (idx - 1) * tstep;
    endfunction

endpackage

// File: rtl/thermo_bp_table.sv
module thermo_bp_table #(
    parameter int DATA_W = 10,
    parameter int IDX_W  = 6,
    parameter int NPTS   = 34,
    parameter int C_RISE = 400,
    parameter int C_FALL = 900,
    parameter int STEP   = 8,
    parameter int BEND   = 3,
    parameter int T0     = -40000,
    parameter int TSTEP  = 5000,
    parameter int PORTS  = 2
) (
    input  logic                          fall,
    input  logic [PORTS-1:0][IDX_W-1:0]   idx,
    output logic [PORTS-1:0][DATA_W-1:0]  code,
    output logic [PORTS-1:0][31:0]        temp
);
    import thermo_pkg::*;

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        assign code[p] = DATA_W'(bp_code(fall, int'(idx[p]), DATA_W, NPTS,
                                         C_RISE, C_FALL, STEP, BEND));
        assign temp[p] = 32'(bp_temp(int'(idx[p]), NPTS, T0, TSTEP));
    end

endmodule

// File: rtl/thermo_seq_div.sv
module thermo_seq_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic [W:0]       rem;
        logic [W-1:0]     quo;
        logic [W-1:0]     den;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } div_t;

    div_t q, d;
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        shifted = {q.rem[W-1:0], q.quo[W-1]};
        trial   = shifted - {1'b0, q.den};
        if (start) begin
            d.rem  = '0;
            d.quo  = dividend;
            d.den  = divisor;
            d.cnt  = CNT_W'(W);
            d.busy = 1'b1;
        end else if (q.busy) begin
            if (!trial[W]) begin
                d.rem = trial;
                d.quo = {q.quo[W-2:0], 1'b1};
            end else begin
                d.rem = shifted;
                d.quo = {q.quo[W-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done     = q.done;
    assign quotient = q.quo;

    // R8
    div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> divisor != '0);

    // R8
    div_single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/thermo_code_conv.sv
module thermo_code_conv #(
    parameter int IN_W   = 12,
    parameter int DATA_W = 10,
    parameter int NPTS   = 34,
    parameter int C_RISE = 400,
    parameter int C_FALL = 900,
    parameter int STEP   = 8,
    parameter int BEND   = 3,
    parameter int T0     = -40000,
    parameter int TSTEP  = 5000,
    parameter int TEMP_W = 32,
    parameter int DIV_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [IN_W-1:0]          in_code,
    input  logic                     in_fall,
    output logic                     out_valid,
    output logic signed [TEMP_W-1:0] out_temp,
    output logic                     out_err
);
    import thermo_pkg::*;

    localparam int IDX_W    = $clog2(NPTS + 3);
    localparam int LEN_RISE = NPTS + 2;
    localparam int LEN_FALL = NPTS + 1;
    localparam int T_TOP    = T0 + (NPTS - 1) * TSTEP;
    localparam logic [DATA_W-1:0] FLOOR_RISE =
        DATA_W'(bp_code(1'b0, 1, DATA_W, NPTS, C_RISE, C_FALL, STEP, BEND));
    localparam logic [DATA_W-1:0] FLOOR_FALL =
        DATA_W'(bp_code(1'b1, NPTS, DATA_W, NPTS, C_RISE, C_FALL, STEP, BEND));

    typedef struct packed {
        conv_state_e              st;
        logic [DATA_W-1:0]        code;
        logic                     fall;
        logic [IDX_W-1:0]         lo;
        logic [IDX_W-1:0]         hi;
        logic signed [TEMP_W-1:0] base;
        logic signed [TEMP_W-1:0] temp;
        logic                     err;
    } conv_t;

    conv_t q, d;

    logic [IDX_W-1:0]            mid;
    logic [1:0][IDX_W-1:0]       tbl_idx;
    logic [1:0][DATA_W-1:0]      tbl_code;
    logic [1:0][31:0]            tbl_temp;
    logic [DATA_W-1:0]           code_m;
    logic [DATA_W-1:0]           c_mid, c_prev;
    logic [DATA_W-1:0]           gap_in, gap_bp;
    logic [31:0]                 t_step;
    logic                        hit, go_up, under;
    logic                        div_start, div_done;
    logic [DIV_W-1:0]            div_dvd, div_dvs, div_quo;

    assign mid        = IDX_W'(({1'b0, q.lo} + {1'b0, q.hi}) >> 1);
    assign tbl_idx[0] = mid;
    assign tbl_idx[1] = mid - 1'b1;

    thermo_bp_table #(
        .DATA_W (DATA_W), .IDX_W (IDX_W), .NPTS (NPTS),
        .C_RISE (C_RISE), .C_FALL (C_FALL), .STEP (STEP), .BEND (BEND),
        .T0 (T0), .TSTEP (TSTEP), .PORTS (2)
    ) u_table (
        .fall (q.fall),
        .idx  (tbl_idx),
        .code (tbl_code),
        .temp (tbl_temp)
    );

    thermo_seq_div #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_dvd),
        .divisor  (div_dvs),
        .done     (div_done),
        .quotient (div_quo)
    );

    always_comb begin
        code_m = in_code[DATA_W-1:0];
        under  = in_fall ? (code_m < FLOOR_FALL) : (code_m < FLOOR_RISE);
        c_mid  = tbl_code[0];
        c_prev = tbl_code[1];
        t_step = tbl_temp[0] - tbl_temp[1];
        gap_in = (c_prev > q.code) ? (c_prev - q.code) : (q.code - c_prev);
        gap_bp = (c_prev > c_mid) ? (c_prev - c_mid) : (c_mid - c_prev);
        hit    = q.fall ? (c_prev > q.code && q.code >= c_mid)
                        : (c_prev < q.code && q.code <= c_mid);
        go_up  = q.fall ? (q.code < c_mid) : (q.code > c_mid);
    end

    always_comb begin
        d         = q;
        div_start = 1'b0;
        div_dvd   = DIV_W'(t_step) * DIV_W'(gap_in);
        div_dvs   = DIV_W'(gap_bp);
        unique case (q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    d.code = code_m;
                    d.fall = in_fall;
                    if (under) begin
                        d.err  = 1'b1;
                        d.temp = '0;
                        d.st   = ST_DONE;
                    end else begin
                        d.err = 1'b0;
                        d.lo  = IDX_W'(1);
                        d.hi  = in_fall ? IDX_W'(LEN_FALL - 1) : IDX_W'(LEN_RISE - 1);
                        d.st  = ST_SEARCH;
                    end
                end
            end
            ST_SEARCH: begin
                if (q.lo > q.hi) begin
                    d.err  = 1'b1;
                    d.temp = '0;
                    d.st   = ST_DONE;
                end else if (hit) begin
                    div_start = 1'b1;
                    d.base    = $signed(TEMP_W'(tbl_temp[1]));
                    d.st      = ST_DIV;
                end else if (go_up) begin
                    d.lo = mid + 1'b1;
                end else begin
                    d.hi = mid - 1'b1;
                end
            end
            ST_DIV: begin
                if (div_done) begin
                    d.temp = q.base + $signed(TEMP_W'(div_quo));
                    d.st   = ST_DONE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready  = (q.st == ST_IDLE);
    assign out_valid = (q.st == ST_DONE);
    assign out_temp  = q.temp;
    assign out_err   = q.err;

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R2
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (!out_valid && in_ready));

    // R6
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> out_temp == '0);

    // R10
    temp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> (out_temp >= T0 && out_temp <= T_TOP));

    // R8
    search_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SEARCH) |-> q.lo != '0);

endmodule

// File: tb/tb_thermo_code_conv.sv
module tb_thermo_code_conv;

    localparam int IN_W   = 12;
    localparam int DATA_W = 10;
    localparam int NPTS   = 34;
    localparam int C_RISE = 400;
    localparam int C_FALL = 900;
    localparam int STEP   = 8;
    localparam int BEND   = 3;
    localparam int T0     = -40000;
    localparam int TSTEP  = 5000;
    localparam int FULL   = (1 << DATA_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [IN_W-1:0] in_code = '0;
    logic in_fall = 1'b0;
    logic in_ready, out_valid, out_err;
    logic signed [31:0] out_temp;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int    exp_t_q[$];
    bit    exp_e_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    thermo_code_conv dut (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready),
        .in_code (in_code), .in_fall (in_fall),
        .out_valid (out_valid), .out_temp (out_temp), .out_err (out_err)
    );

    // Reference curve from R4/R5
    function automatic int m_code(bit fall, int i);
        int k = i - 1;
        if (i == 0) return fall ? FULL : 0;
        if (i > NPTS) return FULL;
        return fall ? C_FALL - k * STEP - k / BEND : C_RISE + k * STEP + k / BEND;
    endfunction

    function automatic int m_temp(int i);
        if (i == 0) return T0;
        if (i > NPTS) return T0 + (NPTS - 1) * TSTEP;
        return T0 + (i - 1) * TSTEP;
    endfunction

    task automatic model(input int raw, input bit fall, output int t, output bit e);
        int c = raw & FULL;
        int len = fall ? NPTS + 1 : NPTS + 2;
        int sel = -1;
        longint num;
        longint den;
        for (int i = 1; i < len; i++) begin
            if (sel < 0) begin
                if (!fall && m_code(0, i - 1) < c && c <= m_code(0, i)) sel = i;
                if (fall && m_code(1, i - 1) > c && c >= m_code(1, i)) sel = i;
            end
        end
        if ((!fall && c < m_code(0, 1)) || (fall && c < m_code(1, NPTS)) || sel < 0) begin
            t = 0; e = 1'b1;
        end else begin
            num = longint'(m_temp(sel) - m_temp(sel - 1));
            num = num * ((m_code(fall, sel - 1) > c) ? m_code(fall, sel - 1) - c
                                                      : c - m_code(fall, sel - 1));
            den = (m_code(fall, sel - 1) > m_code(fall, sel))
                  ? m_code(fall, sel - 1) - m_code(fall, sel)
                  : m_code(fall, sel) - m_code(fall, sel - 1);
            t = m_temp(sel - 1) + int'(num / den);
            e = 1'b0;
        end
    endtask

    task automatic push_send(input int raw, input bit fall, input int t, input bit e, input string tag);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_code  = IN_W'(raw);
        in_fall  = fall;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        exp_t_q.push_back(t);
        exp_e_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic send_model(input int raw, input bit fall, input string tag);
        int t;
        bit e;
        model(raw, fall, t, e);
        push_send(raw, fall, t, e, tag);
    endtask

    // Per-cycle comparison against the reference queue
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (in_ready !== (exp_t_q.size() == 0)) begin
                failures++;
                $display("FAIL R2 in_ready=%0b expected=%0b", in_ready, exp_t_q.size() == 0);
            end
            if (out_valid) begin
                if (exp_t_q.size() == 0) begin
                    failures++;
                    $display("FAIL R2 unexpected out_valid actual=1 expected=0");
                end else begin
                    checks++;
                    if (out_err !== exp_e_q[0] || (!exp_e_q[0] && out_temp !== exp_t_q[0])
                        || (exp_e_q[0] && out_temp !== 0)) begin
                        failures++;
                        $display("FAIL %s temp=%0d err=%0b expected temp=%0d err=%0b",
                                 tag_q[0], out_temp, out_err, exp_t_q[0], exp_e_q[0]);
                    end
                    void'(exp_t_q.pop_front());
                    void'(exp_e_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
        end
    end

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (finished) disable watchdog;
        end
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 in_ready=%0b out_valid=%0b expected 1 0", in_ready, out_valid);
        end

        // Rising curve, hand-computed values
        push_send(400,  0, -40000, 0, "R8 rise exact entry1");
        push_send(404,  0, -37500, 0, "R8 rise midpoint");
        push_send(401,  0, -39375, 0, "R8 rise fraction");
        push_send(408,  0, -35000, 0, "R4 rise entry2");
        push_send(420,  0, -27778, 0, "R4 rise uneven step");
        push_send(675,  0, 125000, 0, "R9 rise top breakpoint");
        push_send(800,  0, 125000, 0, "R9 rise clamp");
        push_send(1023, 0, 125000, 0, "R9 rise full scale");
        push_send(399,  0, 0, 1, "R6 rise below floor");
        push_send(0,    0, 0, 1, "R6 rise zero");
        push_send(3476, 0, -37500, 0, "R3 rise upper bits");

        // Falling curve, hand-computed values
        push_send(900,  1, -40000, 0, "R5 fall entry1");
        push_send(896,  1, -37500, 0, "R8 fall midpoint");
        push_send(880,  1, -27778, 0, "R5 fall uneven step");
        push_send(950,  1, -40000, 0, "R9 fall clamp");
        push_send(625,  1, 125000, 0, "R5 fall last entry");
        push_send(1023, 1, 0, 1, "R7 fall full scale");
        push_send(624,  1, 0, 1, "R7 fall below floor");
        push_send(1920, 1, -37500, 0, "R3 fall upper bits");

        // Sweeps against the behavioural model
        for (int c = 0; c < 1024; c += 3) send_model(c, 1'b0, "R10 rise sweep");
        for (int c = 0; c < 1024; c += 3) send_model(c, 1'b1, "R10 fall sweep");

        while (exp_t_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule